// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the station side of a clause-22 MDIO management link to an external PHY. Software places a 32-bit frame word in a frame register, and that write starts a transaction. The block makes a management clock from the system clock and shifts the frame out on the data line, most significant bit first. On a read it lets go of the line so the PHY can return 16 data bits, and it writes those bits back into the low half of the frame register.

A control register sets how fast the management clock runs and whether the 32-bit preamble is sent. The clock divider reads a live 6-bit field. The value zero stops the clock and holds it low. A new value starts to apply only at the next clock edge.

Software watches the busy flag, or waits for the one-cycle done pulse, so that it does not rewrite the frame register while bits are still being sent. The data line is presented as three plain signals: output value, output enable and input value. An external pad joins them into one bidirectional line.

Top module: `mdio_frame_master`

## Requirements
- R1: With a constant speed field S (control bits 6..1) that is not zero, each high phase and each low phase of mdc lasts exactly S system clock cycles.
- R2: When the speed field is zero, mdc parks low. A frame register write in that state is stored but starts no frame: busy stays 0, mdc stays 0 and doneIrq never pulses.
- R3: When the speed field changes while mdc runs, the half-period already in progress keeps its old length. The new value sets the length of every half-period after the next mdc edge.
- R4: When control bit 7 is 0, every frame begins with 32 consecutive ones on mdoOut. When bit 7 is 1, the frame begins directly with frame register bit 31.
- R5: The frame bits are sent from frame register bit 31 down to bit 0. mdoOut changes only where mdc falls, so it is stable at every rising edge of mdc while mdoEn is 1.
- R6: Opcode bits 29..28 equal to 2'b10 select a read and 2'b01 a write. In a read, mdoEn drops from the bit that comes from frame register bit 16 (the second turnaround bit) onward. mdiIn is sampled at the next 16 rising edges of mdc, and those bits replace frame register bits 15..0 at the end of the frame, first-sampled bit in bit 15. Bits 31..16 keep their values.
- R7: A frame register write during a frame does not start a new frame. The bits not yet sent come from the new value.
- R8: busy reads 1 in the cycle after a frame register write made while the speed field is not zero. At the end of the frame, doneIrq is high for exactly one cycle, and busy reads 0 in that same cycle. mdoEn is 1 only while busy is 1.
- R9: ctrlRdData returns the preamble-disable bit at bit 7 and the speed field at bits 6..1. Bits 31..8 and bit 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frameWrEn | input | 1 | Frame register write strobe |
| frameWrData | input | 32 | Frame register write value |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 7 | Control write bits 7..1 (bit 7 preamble disable, 6..1 speed) |
| frameRdData | output | 32 | Frame register contents |
| ctrlRdData | output | 32 | Control register readback |
| busy | output | 1 | A frame is pending or being shifted |
| doneIrq | output | 1 | One-cycle frame completion pulse |
| mdc | output | 1 | Management clock |
| mdoOut | output | 1 | Management data output value |
| mdoEn | output | 1 | Management data output enable |
| mdiIn | input | 1 | Management data input from the line |

## Verification
The hardest case to reach from the ports is a speed change that lands inside a half-period. The write has to arrive while the old length is still counting down. The stimulus waits until mdc has just risen, writes a new speed in that cycle, and then measures the lengths of the high and low phases that follow. A second hard case is a frame register rewrite in the middle of a frame. The bench counts the bits its PHY model has captured and writes the new value while the preamble is still being sent. It then checks that the frame part of the captured stream matches the new value. Random frames with random speeds, preamble settings and opcodes cover the usual paths. A bench PHY model answers reads with random data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W = 32;
  localparam int PRE_LEN = 32;
  localparam int RD_W    = 16;
  localparam int SPD_W   = 6;
  localparam int IDX_W   = $clog2(PRE_LEN + FRAME_W);

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic             lineOn;   // a frame bit is on the line
    logic             inPre;    // current bit is preamble
    logic             shiftIn;  // capture mdiIn now
    logic             commit;   // frame ends this cycle
    logic [IDX_W-1:0] frmIdx;   // bit position within the frame word
  } strobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int SPD_BITS = SPD_W,
  parameter int PRE_BITS = PRE_LEN,
  parameter int FRM_BITS = FRAME_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SPD_BITS-1:0] spd,
  input  logic                preDis,
  input  logic                frameWrEn,
  output logic                mdc,
  output logic                busy,
  output logic                doneIrq,
  output strobe_t             stb
);
  localparam logic [IDX_W-1:0] LAST_PRE = IDX_W'(PRE_BITS + FRM_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_NOP = IDX_W'(FRM_BITS - 1);

  logic [SPD_BITS-1:0] divCnt, curHalf;
  logic                mdcQ, tog, fallEv, riseEv;
  logic                busyQ, activeQ, preOnQ, doneQ;
  logic [IDX_W-1:0]    cnt, lastIdx;
  logic                startOk, finish;

  // clock divider: half-period length is latched at each mdc edge
  assign tog    = (curHalf != '0) && (divCnt == curHalf - 1'b1) && !((spd == '0) && !mdcQ);
  assign fallEv = tog && mdcQ;
  assign riseEv = tog && !mdcQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdcQ    <= 1'b0;
      divCnt  <= '0;
      curHalf <= '0;
    end else if (curHalf == '0) begin
      mdcQ    <= 1'b0;
      divCnt  <= '0;
      curHalf <= spd;
    end else if (divCnt == curHalf - 1'b1) begin
      divCnt  <= '0;
      curHalf <= spd;
      if (tog) mdcQ <= ~mdcQ;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // frame sequencing
  assign startOk = frameWrEn && (spd != '0) && !busyQ;
  assign lastIdx = preOnQ ? LAST_PRE : LAST_NOP;
  assign finish  = busyQ && activeQ && fallEv && (cnt == lastIdx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ   <= 1'b0;
      activeQ <= 1'b0;
      preOnQ  <= 1'b0;
      doneQ   <= 1'b0;
      cnt     <= '0;
    end else begin
      doneQ <= 1'b0;
      if (startOk) begin
        busyQ   <= 1'b1;
        activeQ <= 1'b0;
      end else if (busyQ && fallEv) begin
        if (!activeQ) begin
          activeQ <= 1'b1;
          cnt     <= '0;
          preOnQ  <= !preDis;
        end else if (finish) begin
          busyQ   <= 1'b0;
          activeQ <= 1'b0;
          doneQ   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb.lineOn  = activeQ;
    stb.inPre   = preOnQ && (cnt < IDX_W'(PRE_BITS));
    stb.frmIdx  = preOnQ ? cnt - IDX_W'(PRE_BITS) : cnt;
    stb.shiftIn = riseEv && activeQ && !stb.inPre;
    stb.commit  = finish;
  end

  assign mdc     = mdcQ;
  assign busy    = busyQ;
  assign doneIrq = doneQ;
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
#(
  parameter int SPD_BITS = SPD_W,
  parameter int FRM_BITS = FRAME_W,
  parameter int RD_BITS  = RD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frameWrEn,
  input  logic [FRM_BITS-1:0] frameWrData,
  input  logic                ctrlWrEn,
  input  logic [7:1]          ctrlWrData,
  input  logic                mdiIn,
  input  strobe_t             stb,
  output logic [SPD_BITS-1:0] spd,
  output logic                preDis,
  output logic [FRM_BITS-1:0] frameQ,
  output logic                mdoOut,
  output logic                mdoEn
);
  localparam int               SEL_W    = $clog2(FRM_BITS);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(FRM_BITS - RD_BITS - 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(FRM_BITS - RD_BITS);

  logic [RD_BITS-1:0] rdShift;
  logic               isRead;
  logic [SEL_W-1:0]   bitSel;

  assign isRead = (frameQ[FRM_BITS-3:FRM_BITS-4] == 2'b10);
  assign bitSel = SEL_W'(FRM_BITS - 1) - stb.frmIdx[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd    <= '0;
      preDis <= 1'b0;
    end else if (ctrlWrEn) begin
      spd    <= ctrlWrData[SPD_BITS:1];
      preDis <= ctrlWrData[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameQ  <= '0;
      rdShift <= '0;
    end else begin
      if (stb.shiftIn && isRead && (stb.frmIdx >= DAT_IDX))
        rdShift <= {rdShift[RD_BITS-2:0], mdiIn};
      if (stb.commit && isRead)
        frameQ[RD_BITS-1:0] <= rdShift;
      if (frameWrEn)
        frameQ <= frameWrData;
    end
  end

  assign mdoOut = stb.lineOn && (stb.inPre || frameQ[bitSel]);
  assign mdoEn  = stb.lineOn && !(isRead && !stb.inPre && (stb.frmIdx >= TA2_IDX));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frameWrEn,
  input  logic [31:0] frameWrData,
  input  logic        ctrlWrEn,
  input  logic [7:1]  ctrlWrData,
  output logic [31:0] frameRdData,
  output logic [31:0] ctrlRdData,
  output logic        busy,
  output logic        doneIrq,
  output logic        mdc,
  output logic        mdoOut,
  output logic        mdoEn,
  input  logic        mdiIn
);
  strobe_t          stb;
  logic [SPD_W-1:0] spd;
  logic             preDis;

  mdio_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .spd(spd), .preDis(preDis),
    .frameWrEn(frameWrEn), .mdc(mdc), .busy(busy), .doneIrq(doneIrq), .stb(stb)
  );

  mdio_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .frameWrEn(frameWrEn), .frameWrData(frameWrData),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .mdiIn(mdiIn), .stb(stb),
    .spd(spd), .preDis(preDis), .frameQ(frameRdData), .mdoOut(mdoOut), .mdoEn(mdoEn)
  );

  assign ctrlRdData = {24'd0, preDis, spd, 1'b0};
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrlRdData,
  input logic        mdc,
  input logic        mdoOut,
  input logic        mdoEn,
  input logic        busy,
  input logic        doneIrq
);
  // R2
  mdc_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlRdData[6:1] == 6'd0 && !mdc) |=> !mdc);

  // R5
  mdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdoEn && $rose(mdc)) |-> $stable(mdoOut));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneIrq |=> !doneIrq);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneIrq |-> !busy);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> doneIrq);

  // R8
  drive_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdoEn |-> busy);

  // R9
  always_comb begin
    if (rst_n) begin
      ctrl_rsvd_chk: assert (ctrlRdData[31:8] == 24'd0 && ctrlRdData[0] == 1'b0);
    end
  end
endmodule

bind mdio_frame_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrlRdData(ctrlRdData), .mdc(mdc),
  .mdoOut(mdoOut), .mdoEn(mdoEn), .busy(busy), .doneIrq(doneIrq)
);

// File: tb/sim_mdio_frame_master.sv
`timescale 1ns/1ps
module sim_mdio_frame_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frameWrEn = 1'b0;
  logic [31:0] frameWrData = '0;
  logic        ctrlWrEn = 1'b0;
  logic [7:1]  ctrlWrData = '0;
  logic [31:0] frameRdData, ctrlRdData;
  logic        busy, doneIrq, mdc, mdoOut, mdoEn;
  logic        mdiIn = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  mdio_frame_master u0 (.*);

  always #10 clk = ~clk;

  // bench PHY model
  logic [15:0] phyData = '0;
  int          phyK = 0;
  logic [63:0] capBits = '0;
  int          capN = 0;

  always @(negedge mdc) begin
    #1;
    if (busy && !mdoEn) begin
      if (phyK == 0) mdiIn = 1'b0;
      else if (phyK <= 16) mdiIn = phyData[16-phyK];
      phyK++;
    end
  end

  always @(posedge mdc) begin
    #1;
    if (mdoEn) begin
      capBits = {capBits[62:0], mdoOut};
      capN++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setCtrl(input bit pd, input logic [5:0] s);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = {pd, s};
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  function automatic logic [31:0] mkFrame(input bit rd, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
  endfunction

  // expected stream of driven bits and its length
  function automatic logic [63:0] expBits(input bit pd, input logic [31:0] f, output int n);
    logic [63:0] v = '0;
    int nf = (f[29:28] == 2'b10) ? 15 : 32;
    n = 0;
    if (!pd) begin v = {32'd0, 32'hFFFF_FFFF}; n = 32; end
    for (int i = 31; i > 31 - nf; i--) begin v = {v[62:0], f[i]}; n++; end
    return v;
  endfunction

  task automatic runFrame(input bit pd, input logic [5:0] s, input logic [31:0] f, input logic [15:0] pdat);
    int n, dones;
    logic [63:0] e;
    logic [31:0] expRd;
    setCtrl(pd, s);
    phyData = pdat; phyK = 0; capN = 0; capBits = '0;
    @(negedge clk);
    frameWrEn = 1'b1; frameWrData = f;
    @(negedge clk);
    frameWrEn = 1'b0;
    chk(busy == 1'b1, "R8 busy after write", 64'(busy), 1);
    dones = 0;
    while (dones == 0) begin
      @(negedge clk);
      if (doneIrq) begin
        dones++;
        chk(busy == 1'b0, "R8 busy clear at done", 64'(busy), 0);
      end
    end
    @(negedge clk);
    chk(doneIrq == 1'b0, "R8 done single cycle", 64'(doneIrq), 0);
    e = expBits(pd, f, n);
    chk(capN == n, "R4 driven bit count", 64'(capN), 64'(n));
    chk(capBits == e, "R5 driven bit stream", capBits, e);
    expRd = (f[29:28] == 2'b10) ? {f[31:16], pdat} : f;
    chk(frameRdData == expRd, "R6 frame register after frame", 64'(frameRdData), 64'(expRd));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int hi, lo, n;
    logic [63:0] e;
    logic [31:0] fa, fb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && doneIrq == 0 && mdc == 0 && mdoEn == 0, "R8 reset outputs",
        64'({busy, doneIrq, mdc, mdoEn}), 0);
    chk(ctrlRdData == 0 && frameRdData == 0, "R9 reset registers", {ctrlRdData, frameRdData}, 0);

    // R9: reserved bits read zero
    setCtrl(1'b1, 6'h3F);
    chk(ctrlRdData == 32'h0000_00FE, "R9 ctrl readback", 64'(ctrlRdData), 64'h00FE);
    setCtrl(1'b0, 6'd0);
    chk(ctrlRdData == 32'h0, "R9 ctrl cleared", 64'(ctrlRdData), 0);

    // R2: zero speed parks clock and blocks frames
    repeat (100) @(negedge clk);
    @(negedge clk); frameWrEn = 1'b1; frameWrData = mkFrame(1'b0, 5'd3, 5'd4, 16'hBEEF);
    @(negedge clk); frameWrEn = 1'b0;
    hi = 0;
    repeat (60) begin
      @(negedge clk);
      if (mdc || busy || doneIrq) hi++;
    end
    chk(hi == 0, "R2 no clock or frame at zero speed", 64'(hi), 0);
    chk(frameRdData == mkFrame(1'b0, 5'd3, 5'd4, 16'hBEEF), "R2 value stored",
        64'(frameRdData), 64'(mkFrame(1'b0, 5'd3, 5'd4, 16'hBEEF)));

    // R1: half periods with constant speed
    for (int s = 1; s <= 7; s += 3) begin
      setCtrl(1'b0, 6'(s));
      while (mdc) @(negedge clk);
      while (!mdc) @(negedge clk);
      hi = 0; while (mdc) begin hi++; @(negedge clk); end
      lo = 0; while (!mdc) begin lo++; @(negedge clk); end
      chk(hi == s && lo == s, "R1 half periods", {32'(hi), 32'(lo)}, {32'(s), 32'(s)});
    end

    // R3: change speed just after a rising edge
    setCtrl(1'b0, 6'd5);
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = {1'b0, 6'd3};
    hi = 1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    while (mdc) begin hi++; @(negedge clk); end
    lo = 0; while (!mdc) begin lo++; @(negedge clk); end
    chk(hi == 5, "R3 current half keeps old length", 64'(hi), 5);
    chk(lo == 3, "R3 next half uses new length", 64'(lo), 3);

    // directed frames: R4 R5 R6
    runFrame(1'b0, 6'd2, mkFrame(1'b0, 5'h11, 5'h05, 16'hA5C3), 16'h0);
    runFrame(1'b1, 6'd1, mkFrame(1'b0, 5'h1F, 5'h1F, 16'hFFFF), 16'h0);
    runFrame(1'b0, 6'd3, mkFrame(1'b1, 5'h01, 5'h02, 16'h0000), 16'h8001);
    runFrame(1'b1, 6'd2, mkFrame(1'b1, 5'h0A, 5'h15, 16'h1234), 16'h6DB6);

    // R7: rewrite during the preamble
    setCtrl(1'b0, 6'd2);
    fa = mkFrame(1'b0, 5'h02, 5'h03, 16'h0F0F);
    fb = mkFrame(1'b0, 5'h1C, 5'h07, 16'hC0DE);
    phyK = 0; capN = 0; capBits = '0;
    @(negedge clk); frameWrEn = 1'b1; frameWrData = fa;
    @(negedge clk); frameWrEn = 1'b0;
    wait (capN == 5);
    @(negedge clk); frameWrEn = 1'b1; frameWrData = fb;
    @(negedge clk); frameWrEn = 1'b0;
    hi = 0;
    while (busy) begin @(negedge clk); if (doneIrq) hi++; end
    repeat (10) begin @(negedge clk); if (doneIrq) hi++; end
    e = expBits(1'b0, fb, n);
    chk(capBits == e && capN == n, "R7 remaining bits from new value", capBits, e);
    chk(hi == 1 && !busy, "R7 no restart", 64'(hi), 1);

    // random frames
    for (int i = 0; i < 8; i++) begin
      bit rd = 1'($urandom);
      bit pd = 1'($urandom);
      logic [5:0] s = 6'($urandom_range(1, 6));
      logic [31:0] f = mkFrame(rd, 5'($urandom), 5'($urandom), 16'($urandom));
      runFrame(pd, s, f, 16'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule